// File: doc/BRIEF.md
# Exception Priority Resolver and Vectoring

This block picks, every clock, the exception or interrupt that the processor should take next. It looks at the pending bits of nine system sources and of a parameterised number of peripheral interrupts. Each source with a configurable level has an enable bit and a programmable priority. The block compares the best pending candidate against the level of the exception now in service. If the candidate wins, it raises a one-cycle take strobe with the vector number and the byte offset of that vector in the table.

Levels are numbered so that a smaller value is more urgent. Three sources sit above every programmable value and have fixed levels: reset, the non-maskable interrupt and hard fault. Programmable priorities follow them in an unsigned field. A small write/read port holds the per-source enable and priority settings. The core reports the level it is currently serving through `cur_busy`/`cur_lvl`, and it takes the registered decision one cycle later.

Top module: `exc_arbiter`

## Requirements
- R1: While `rst_n` is low, `take`, `vec` and `vec_off` are 0, and every configuration entry reads back as 0 (disabled, priority 0).
- R2: On the first clock edge at which `rst_n` is high, the block takes vector 1 (offset 4), whatever is pending or active. The forced take happens once.
- R3: Internal levels are: 0 reset, 1 non-maskable (`sys_pend[0]`), 2 hard fault (`sys_pend[1]`), and 3+p for a configurable source with priority p. The two fixed pending sources therefore beat any configurable one, and the non-maskable source beats hard fault.
- R4: The non-maskable and hard-fault sources ignore every enable bit. The non-maskable source is taken whenever it is pending, unless the active level is 0 or 1. In other words, only reset or another non-maskable activation blocks it.
- R5: A configurable source can win only while its enable bit is 1. `sys_pend[2..8]` are the memory-management, bus, usage, supervisor-call, debug-monitor, pendable-service and tick sources, and `irq_pend[k]` is peripheral interrupt k.
- R6: Among the eligible pending sources, the one with the lowest level wins. On equal levels, the one with the lower vector number wins.
- R7: A take happens only when the winner's level is strictly below the active level. The active level is `cur_lvl` when `cur_busy` is 1, and 2^PRIO_W+3 (one step below the lowest programmable level) when `cur_busy` is 0. An equal level never preempts.
- R8: Vectors are 2 for non-maskable, 3 for hard fault, 4/5/6 for memory/bus/usage, 11/12/14/15 for supervisor-call, debug-monitor, pendable-service and tick, and 16+k for interrupt k. `vec_off` is 4 times `vec`. Vectors 0, 7 to 10 and 13 are never taken, and when `take` is 0 both `vec` and `vec_off` are 0.
- R9: Configuration address j selects entry j. Entries 0 to 6 follow the `sys_pend[2..8]` order, and entry 7+k belongs to interrupt k. Data bit 0 is the enable and bits PRIO_W:1 are the priority. `cfg_rdata` shows the entry at `cfg_addr` without delay. Addresses at or above 7+NUM_IRQ read as 0, and writes to them change nothing.
- R10: `take`/`vec` are registered and reflect the inputs and configuration that held before the edge. A configuration write in the same cycle is seen only from the next decision on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_pend | input | 9 | Pending system sources, bit order per R3/R5 |
| irq_pend | input | NUM_IRQ | Pending peripheral interrupts |
| cur_busy | input | 1 | An exception is in service |
| cur_lvl | input | LVL_W (4) | Internal level of the exception in service |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (4) | Configuration entry address |
| cfg_wdata | input | PRIO_W+1 | {priority, enable} to write |
| cfg_rdata | output | PRIO_W+1 | {priority, enable} of the addressed entry |
| take | output | 1 | Take-exception strobe |
| vec | output | VEC_W (5) | Vector number of the taken exception |
| vec_off | output | VEC_W+2 | Vector table byte offset |

## Verification
Two things can happen in the same cycle: a configuration write and an arbitration decision. The bench provokes this by writing a new enable or priority to the source that is winning in that same cycle. The decision registered at that edge must still follow the old setting, and the next decision must follow the new one. A long mixed sweep also issues random writes alongside random pending, busy and level patterns. Every decision is compared against a reference that updates its copy of the configuration only after it has computed the expected vector.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
   // system sources: non-maskable, hard fault, then seven configurable ones
   localparam int SYS_SRC  = 9;
   localparam int CFG_SYS  = 7;
   localparam int LVL_RST  = 0;
   localparam int LVL_NMI  = 1;
   localparam int LVL_HARD = 2;
   localparam int LVL_BASE = 3;

   // source index (vector order, reset excluded) to vector number
   function automatic int src_vector(input int s);
      if (s < 5)      return s + 2;
      else if (s < 7) return s + 6;
      else            return s + 7;
   endfunction
endpackage

// File: rtl/exc_cfg_regs.sv
module exc_cfg_regs #(
   parameter int NCFG   = 15,
   parameter int PRIO_W = 3,
   parameter int AW     = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [AW-1:0]                 addr,
   input  logic [PRIO_W:0]               wdata,
   output logic [PRIO_W:0]               rdata,
   output logic [NCFG-1:0]               en,
   output logic [NCFG-1:0][PRIO_W-1:0]   prio
);
   for (genvar j = 0; j < NCFG; j++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en[j]   <= 1'b0;
            prio[j] <= '0;
         end else if (we && (addr == AW'(j))) begin
            en[j]   <= wdata[0];
            prio[j] <= wdata[PRIO_W:1];
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int j = 0; j < NCFG; j++) begin
         if (addr == AW'(j)) rdata = {prio[j], en[j]};
      end
   end
endmodule

// File: rtl/exc_level_map.sv
module exc_level_map import exc_arb_pkg::*; #(
   parameter int NSRC   = 17,
   parameter int PRIO_W = 3,
   parameter int LVL_W  = 4
) (
   input  logic [NSRC-1:0]                 pend,
   input  logic [NSRC-3:0]                 en,
   input  logic [NSRC-3:0][PRIO_W-1:0]     prio,
   output logic [NSRC-1:0]                 req,
   output logic [NSRC-1:0][LVL_W-1:0]      lvl
);
   for (genvar s = 0; s < NSRC; s++) begin : g_src
      if (s == 0) begin : g_nmi
         assign req[s] = pend[s];
         assign lvl[s] = LVL_W'(LVL_NMI);
      end else if (s == 1) begin : g_hard
         assign req[s] = pend[s];
         assign lvl[s] = LVL_W'(LVL_HARD);
      end else begin : g_cfg
         assign req[s] = pend[s] & en[s-2];
         assign lvl[s] = LVL_W'(LVL_BASE) + LVL_W'(prio[s-2]);
      end
   end
endmodule

// File: rtl/exc_pick.sv
module exc_pick import exc_arb_pkg::*; #(
   parameter int NSRC  = 17,
   parameter int LVL_W = 4,
   parameter int VEC_W = 5
) (
   input  logic [NSRC-1:0]             req,
   input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
   output logic                        found,
   output logic [LVL_W-1:0]            best_lvl,
   output logic [VEC_W-1:0]            best_vec
);
   // ascending scan with strict compare keeps the lower vector on a tie
   always_comb begin
      found    = 1'b0;
      best_lvl = '1;
      best_vec = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (req[s] && (!found || (lvl[s] < best_lvl))) begin
            found    = 1'b1;
            best_lvl = lvl[s];
            best_vec = VEC_W'(src_vector(s));
         end
      end
   end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter import exc_arb_pkg::*; #(
   parameter int  NUM_IRQ = 8,
   parameter int  PRIO_W  = 3,
   localparam int NCFG    = CFG_SYS + NUM_IRQ,
   localparam int NSRC    = SYS_SRC + NUM_IRQ,
   localparam int IDLE    = (1 << PRIO_W) + LVL_BASE,
   localparam int LVL_W   = $clog2(IDLE + 1),
   localparam int VEC_W   = $clog2(16 + NUM_IRQ),
   localparam int AW      = (NCFG > 1) ? $clog2(NCFG) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SYS_SRC-1:0]  sys_pend,
   input  logic [NUM_IRQ-1:0]  irq_pend,
   input  logic                cur_busy,
   input  logic [LVL_W-1:0]    cur_lvl,
   input  logic                cfg_we,
   input  logic [AW-1:0]       cfg_addr,
   input  logic [PRIO_W:0]     cfg_wdata,
   output logic [PRIO_W:0]     cfg_rdata,
   output logic                take,
   output logic [VEC_W-1:0]    vec,
   output logic [VEC_W+1:0]    vec_off
);
   if (PRIO_W < 1 || PRIO_W > 5) begin : g_bad_prio
      $error("exc_arbiter: PRIO_W must lie in 1..5");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > 240) begin : g_bad_irq
      $error("exc_arbiter: NUM_IRQ must lie in 1..240");
   end

   logic [NCFG-1:0]              en;
   logic [NCFG-1:0][PRIO_W-1:0]  prio;
   logic [NSRC-1:0]              req;
   logic [NSRC-1:0][LVL_W-1:0]   lvl;
   logic                         found;
   logic [LVL_W-1:0]             best_lvl;
   logic [VEC_W-1:0]             best_vec;
   logic                         boot_q;
   logic [LVL_W-1:0]             act_lvl;
   logic                         fire;
   logic [VEC_W-1:0]             nxt_vec;

   exc_cfg_regs #(.NCFG(NCFG), .PRIO_W(PRIO_W), .AW(AW)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .en    (en),
      .prio  (prio)
   );

   exc_level_map #(.NSRC(NSRC), .PRIO_W(PRIO_W), .LVL_W(LVL_W)) u_map (
      .pend ({irq_pend, sys_pend}),
      .en   (en),
      .prio (prio),
      .req  (req),
      .lvl  (lvl)
   );

   exc_pick #(.NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_pick (
      .req      (req),
      .lvl      (lvl),
      .found    (found),
      .best_lvl (best_lvl),
      .best_vec (best_vec)
   );

   assign act_lvl = cur_busy ? cur_lvl : LVL_W'(IDLE);
   assign fire    = boot_q | (found & (best_lvl < act_lvl));
   assign nxt_vec = boot_q ? VEC_W'(1) : (fire ? best_vec : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q <= 1'b1;
         take   <= 1'b0;
         vec    <= '0;
      end else begin
         boot_q <= 1'b0;
         take   <= fire;
         vec    <= nxt_vec;
      end
   end

   assign vec_off = {vec, 2'b00};
endmodule

// File: rtl/exc_arb_chk.sv
module exc_arb_chk import exc_arb_pkg::*; #(
   parameter int  NUM_IRQ = 8,
   parameter int  PRIO_W  = 3,
   localparam int IDLE    = (1 << PRIO_W) + LVL_BASE,
   localparam int LVL_W   = $clog2(IDLE + 1),
   localparam int VEC_W   = $clog2(16 + NUM_IRQ)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SYS_SRC-1:0]  sys_pend,
   input logic [NUM_IRQ-1:0]  irq_pend,
   input logic                cur_busy,
   input logic [LVL_W-1:0]    cur_lvl,
   input logic                take,
   input logic [VEC_W-1:0]    vec,
   input logic [VEC_W+1:0]    vec_off
);
   p_boot_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(rst_n, 2)) |-> (take && vec == VEC_W'(1)));

   p_nmi_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sys_pend[0])
       && !$past(cur_busy && (cur_lvl <= LVL_W'(LVL_NMI)))) |-> take);

   p_nmi_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)
       && $past(cur_busy && (cur_lvl == LVL_W'(LVL_NMI)))) |-> !take);

   p_vec_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (vec != '0 && vec != VEC_W'(13)
                && !(vec >= VEC_W'(7) && vec <= VEC_W'(10))));

   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> (vec == '0 && vec_off == '0));

   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)
       && $past(sys_pend == '0 && irq_pend == '0)) |-> !take);
endmodule

bind exc_arbiter exc_arb_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/test_exc_arbiter.sv
module test_exc_arbiter;
   localparam int CLK_P = 10;
   localparam int NI    = 8;
   localparam int PW    = 3;
   localparam int NC    = 7 + NI;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [8:0]    sys_pend = '0;
   logic [NI-1:0] irq_pend = '0;
   logic          cur_busy = 1'b0;
   logic [3:0]    cur_lvl = '0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_addr = '0;
   logic [3:0]    cfg_wdata = '0;
   logic [3:0]    cfg_rdata;
   logic          take;
   logic [4:0]    vec;
   logic [6:0]    vec_off;

   int n_chk = 0;
   int n_bad = 0;
   bit m_en [NC];
   int m_pr [NC];

   always #(CLK_P/2) clk = ~clk;

   exc_arbiter #(.NUM_IRQ(NI), .PRIO_W(PW)) i_exc_arbiter (
      .clk(clk), .rst_n(rst_n), .sys_pend(sys_pend), .irq_pend(irq_pend),
      .cur_busy(cur_busy), .cur_lvl(cur_lvl), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .take(take), .vec(vec), .vec_off(vec_off)
   );

   // reference: signed levels, fixed sources negative, scanned by vector number
   function automatic int model(input logic [8:0] s, input logic [NI-1:0] q,
                                input logic b, input int l);
      int best_l, best_v, act, pl, idx;
      logic p;
      bit e, ok;
      best_l = 1000;
      best_v = 0;
      for (int v = 2; v < 16 + NI; v++) begin
         ok = 1'b1; p = 1'b0; e = 1'b1; pl = 0; idx = -1;
         if (v == 2)       begin p = s[0]; pl = -2; end
         else if (v == 3)  begin p = s[1]; pl = -1; end
         else if (v <= 6)  begin p = s[v-2]; idx = v - 4; end
         else if (v == 11) begin p = s[5]; idx = 3; end
         else if (v == 12) begin p = s[6]; idx = 4; end
         else if (v == 14) begin p = s[7]; idx = 5; end
         else if (v == 15) begin p = s[8]; idx = 6; end
         else if (v >= 16) begin p = q[v-16]; idx = 7 + v - 16; end
         else ok = 1'b0;
         if (idx >= 0) begin e = m_en[idx]; pl = m_pr[idx]; end
         if (ok && p && e && pl < best_l) begin best_l = pl; best_v = v; end
      end
      act = b ? l - 3 : (1 << PW);
      return (best_v != 0 && best_l < act) ? best_v : 0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int j = 0; j < NC; j++) begin m_en[j] = 1'b0; m_pr[j] = 0; end
   endtask

   // one decision: drive, compute expected from old configuration, compare
   task automatic step(input logic [8:0] s, input logic [NI-1:0] q, input logic b,
                       input int l, input logic we, input int a, input int d,
                       input string req);
      int ev;
      sys_pend = s; irq_pend = q; cur_busy = b; cur_lvl = 4'(l);
      cfg_we = we; cfg_addr = 4'(a); cfg_wdata = 4'(d);
      ev = model(s, q, b, l);
      if (we && a < NC) begin m_en[a] = d[0]; m_pr[a] = (d >> 1) & 7; end
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      check(take == (ev != 0) && int'(vec) == ev && int'(vec_off) == 4 * ev,
            req, int'(vec), ev);
   endtask

   task automatic wr(input int a, input int d);
      step('0, '0, 1'b0, 0, 1'b1, a, d, "R9 write");
   endtask

   task automatic do_reset();
      rst_n = 1'b0; sys_pend = '1; irq_pend = '1; cur_busy = 1'b0;
      model_clear();
      repeat (3) @(negedge clk);
      check(take == 1'b0 && vec == '0 && vec_off == '0, "R1 outputs", int'(vec), 0);
      for (int a = 0; a < 16; a++) begin
         cfg_addr = 4'(a);
         #1;
         check(cfg_rdata == '0, "R1 readback", int'(cfg_rdata), 0);
      end
      sys_pend = 9'h1FF; cur_busy = 1'b1; cur_lvl = 4'd0;
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(take && vec == 5'd1 && vec_off == 7'd4, "R2 boot vector", int'(vec), 1);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      // R2: forced take happens only once
      step('0, '0, 1'b0, 0, 1'b0, 0, 0, "R2 once");
      // R4: all enables off, everything pending -> non-maskable
      step(9'h1FF, '1, 1'b0, 0, 1'b0, 0, 0, "R4 nmi ignores enables");
      step(9'h1FF, '1, 1'b1, 2, 1'b0, 0, 0, "R4 nmi preempts hard fault");
      step(9'h1FF, '1, 1'b1, 1, 1'b0, 0, 0, "R4 nmi blocked by nmi");
      step(9'h1FF, '1, 1'b1, 0, 1'b0, 0, 0, "R4 nmi blocked by reset");
      step(9'h002, '0, 1'b0, 0, 1'b0, 0, 0, "R4 hard fault ignores enables");
      // R5: disabled memory fault does not win, then enabled
      step(9'h004, '0, 1'b0, 0, 1'b0, 0, 0, "R5 disabled");
      wr(0, 1);
      step(9'h004, '0, 1'b0, 0, 1'b0, 0, 0, "R5 enabled");
      // R3: hard fault beats priority-0 source
      step(9'h006, '0, 1'b0, 0, 1'b0, 0, 0, "R3 fixed above programmable");
      // R6: priorities and ties
      wr(7, 5); wr(8, 3); wr(3, 3); wr(5, 3);
      cfg_addr = 4'd7; #1;
      check(cfg_rdata == 4'd5, "R9 readback", int'(cfg_rdata), 5);
      step('0, 8'h03, 1'b0, 0, 1'b0, 0, 0, "R6 lower value wins");
      step(9'h0A0, 8'h02, 1'b0, 0, 1'b0, 0, 0, "R6 tie lower vector");
      // R7: strict preemption
      step(9'h020, '0, 1'b1, 4, 1'b0, 0, 0, "R7 equal no preempt");
      step(9'h020, '0, 1'b1, 5, 1'b0, 0, 0, "R7 higher preempts");
      wr(6, 15);
      step(9'h100, '0, 1'b0, 0, 1'b0, 0, 0, "R7 lowest level vs idle");
      // R9: out-of-range address ignored
      wr(15, 15);
      cfg_addr = 4'd15; #1;
      check(cfg_rdata == '0, "R9 unused address", int'(cfg_rdata), 0);
      // R10: write and decision in the same cycle
      step(9'h004, '0, 1'b0, 0, 1'b1, 0, 0, "R10 old setting used");
      step(9'h004, '0, 1'b0, 0, 1'b0, 0, 0, "R10 new setting seen");
      // mixed sweep with concurrent writes (R6 R7 R8 R10)
      for (int i = 0; i < 4000; i++) begin
         step(9'($urandom & $urandom), NI'($urandom & $urandom), 1'($urandom),
              int'($urandom % 12), ($urandom % 4) == 0, int'($urandom % 16),
              int'($urandom % 16), "R8 sweep");
         check(!(vec == 5'd13 || (vec >= 5'd7 && vec <= 5'd10)) && (take || vec == '0),
               "R8 reserved", int'(vec), 0);
         if (i == 2000) do_reset();
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule